// File: doc/BRIEF.md
# Indirect-Addressed Host Register Port

This block lets a microprocessor configure a small control register file over an 8-bit parallel bus. The bus uses active-low read and write strobes and an active-low address-enable pin. Neither strobe is tied to the block's clock. Both strobes are brought into the core clock domain through two-flop synchronizers.

Registers have no direct addresses on the bus. A write with the address enable asserted loads an internal pointer. Reads and writes with the address enable deasserted reach the register that the pointer selects. The pointer stays where it was after each access. The data bus is a tri-state pin: the value and its output enable come out as separate signals.

Every register value is presented to the rest of the chip on one flat configuration bus. Register 0 resets to 0x01 and all other registers reset to 0x00. In this state bit 0 of register 0 selects the internal blue-field source, and all output-enable bits are clear.

Top module: `hostreg_port`

## Requirements
- R1: While `rst_n` is low at a clock edge, every register returns to its default after that edge (register 0 = 0x01, all others = 0x00), and `dout_oe` is 0.
- R2: A write cycle with `aen_n` low loads the pointer from `din` and changes no register on `cfg_bus`.
- R3: A write cycle with `aen_n` high stores `din` in the register the pointer selects. The new value appears on `cfg_bus` within three clock cycles after `wr_n` returns high.
- R4: While `rd_n` is held low, `dout_oe` is 1 and `dout` carries the selected register, starting no later than three clock cycles after the fall. Within three cycles after `rd_n` rises, `dout_oe` is 0.
- R5: A read while the pointer holds an address at or above the register count (6 by default) returns 0x00.
- R6: A data write while the pointer holds an unimplemented address leaves every register unchanged.
- R7: The pointer does not advance after an access, so consecutive data writes and reads reach the same register.
- R8: Bus cycles made while `rst_n` is low are ignored: after release, all registers hold their defaults.
- R9: A data write takes effect only after the write strobe returns high; while `wr_n` stays low, `cfg_bus` keeps its old value.
- R10: A data write changes only the selected register. All other bytes of `cfg_bus` keep their values. Register i occupies bits [8i+7:8i].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_n | input | 1 | Asynchronous active-low read strobe |
| wr_n | input | 1 | Asynchronous active-low write strobe |
| aen_n | input | 1 | Active-low address enable, qualifies writes as pointer loads |
| din | input | 8 | Host data into the port |
| dout | output | 8 | Read data to the host (0 when not driving) |
| dout_oe | output | 1 | Drive enable for the bidirectional data pins |
| cfg_bus | output | 48 | All register values, register i in bits [8i+7:8i] |

## Verification
Data writes are made with patterns 0xA5, 0x3C, 0xFF and 0x81, across registers 0, 2 and 5. These values have alternating bits, both nibbles set and the end bits set, so a swapped or dropped data bit shows up on `cfg_bus`. Writing the same register twice without a new pointer load separates a pointer that stays put from one that advances. Pointer loads of 0x02 and 0x20 separate implemented addresses from unimplemented ones, for both reads and writes. Writes made during reset, and a value sampled while the write strobe is still low, show that only a completed strobe outside reset changes state.

// File: rtl/hostreg_pkg.sv
// Package: shared sizes and reset defaults for the host register port.
// Assumes registers are one byte wide; only register 0 has a non-zero default.
package hostreg_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 8;

    // Reset value of register idx: bit 0 of register 0 selects the blue-field source.
    function automatic logic [DATA_W-1:0] reg_default(input int idx);
        return (idx == 0) ? DATA_W'(1) : '0;
    endfunction
endpackage

// File: rtl/hostreg_sync.sv
// Module: two-flop synchronizer for one active-low strobe, plus rising-edge detect.
// Assumes the strobe idles high; reset loads the idle level so no false edge follows reset.
module hostreg_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_n,
    output logic stage1_n,
    output logic level_n,
    output logic rise
);
    logic s1, s2, s3;

    // Shift the strobe through the synchronizer and the edge-history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
            s3 <= 1'b1;
        end else begin
            s1 <= strobe_n;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign stage1_n = s1;
    assign level_n  = s2;
    assign rise     = s2 & ~s3;
endmodule

// File: rtl/hostreg_regfile.sv
// Module: address pointer and byte-wide register file with read multiplexer.
// Assumes wr_evt is a single-cycle pulse; addr_sel picks a pointer load over a data write.
module hostreg_regfile #(
    parameter int NREG   = 6,
    parameter int DATA_W = 8,
    parameter int ADDR_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_evt,
    input  logic                   addr_sel,
    input  logic [DATA_W-1:0]      wdata,
    output logic [ADDR_W-1:0]      ptr,
    output logic [DATA_W-1:0]      rdata,
    output logic [NREG*DATA_W-1:0] cfg_bus
);
    logic [DATA_W-1:0] regs [NREG];

    // Load the pointer on a write qualified by address enable; never auto-advance.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (wr_evt && addr_sel)
            ptr <= wdata[ADDR_W-1:0];
    end

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        // Store data into this register when the pointer selects it.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[g] <= hostreg_pkg::reg_default(g);
            else if (wr_evt && !addr_sel && ptr == ADDR_W'(g))
                regs[g] <= wdata;
        end
        assign cfg_bus[g*DATA_W +: DATA_W] = regs[g];
    end

    // Select the addressed register for reads; unimplemented addresses read zero.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NREG; i++)
            if (ptr == ADDR_W'(i))
                rdata = regs[i];
    end
endmodule

// File: rtl/hostreg_port.sv
// Module: top of the indirect-addressed parallel host port.
// Assumes host data and address enable are stable while the write strobe is low;
// the value seen on the last sampled low cycle is the one that is used.
module hostreg_port #(
    parameter int NREG   = 6,
    parameter int DATA_W = hostreg_pkg::DATA_W,
    parameter int ADDR_W = hostreg_pkg::ADDR_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rd_n,
    input  logic                   wr_n,
    input  logic                   aen_n,
    input  logic [DATA_W-1:0]      din,
    output logic [DATA_W-1:0]      dout,
    output logic                   dout_oe,
    output logic [NREG*DATA_W-1:0] cfg_bus
);
    localparam int NSTROBE = 2;   // index 0 = read, 1 = write

    logic [NSTROBE-1:0] raw_n, st1_n, lvl_n, rise;
    logic [DATA_W-1:0]  din_q, hold_d, rdata;
    logic               aen_q, hold_a, wr_rise;
    logic [ADDR_W-1:0]  ptr;

    assign raw_n = {wr_n, rd_n};

    for (genvar s = 0; s < NSTROBE; s++) begin : g_sync
        hostreg_sync u_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .strobe_n (raw_n[s]),
            .stage1_n (st1_n[s]),
            .level_n  (lvl_n[s]),
            .rise     (rise[s])
        );
    end

    // Register bus data and address enable alongside the first synchronizer stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            din_q <= '0;
            aen_q <= 1'b0;
        end else begin
            din_q <= din;
            aen_q <= ~aen_n;
        end
    end

    // Keep the data and qualifier seen while the write strobe was last low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_d <= '0;
            hold_a <= 1'b0;
        end else if (!st1_n[1]) begin
            hold_d <= din_q;
            hold_a <= aen_q;
        end
    end

    assign wr_rise = rise[1];

    hostreg_regfile #(
        .NREG   (NREG),
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_evt   (wr_rise),
        .addr_sel (hold_a),
        .wdata    (hold_d),
        .ptr      (ptr),
        .rdata    (rdata),
        .cfg_bus  (cfg_bus)
    );

    // Drive the data pins only while the synchronized read strobe is low.
    always_comb begin
        dout_oe = ~lvl_n[0];
        dout    = dout_oe ? rdata : '0;
    end
endmodule

// File: rtl/hostreg_port_chk.sv
// Module: assertion checker for the host register port, bound into every instance.
module hostreg_port_chk #(
    parameter int NREG   = 6,
    parameter int DATA_W = 8,
    parameter int ADDR_W = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   rd_n,
    input logic                   dout_oe,
    input logic [DATA_W-1:0]      dout,
    input logic [NREG*DATA_W-1:0] cfg_bus,
    input logic [ADDR_W-1:0]      ptr,
    input logic                   wr_evt,
    input logic                   addr_sel
);
    logic [NREG*DATA_W-1:0] dflt;
    always_comb
        for (int i = 0; i < NREG; i++)
            dflt[i*DATA_W +: DATA_W] = hostreg_pkg::reg_default(i);

    AST_DEFAULTS_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> cfg_bus == dflt);                                       // R1
    AST_PTR_ONLY_ON_ADDR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ptr) |-> $past(wr_evt && addr_sel));                           // R2
    AST_CFG_ONLY_ON_DATA_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_bus) |-> $past(wr_evt && !addr_sel));                      // R9
    AST_OE_NEEDS_RD: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_oe && $past(rst_n, 2)) |-> !$past(rd_n, 2));                      // R4
    AST_UNIMPL_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr >= ADDR_W'(NREG)) |-> dout == '0);                                 // R5
endmodule

bind hostreg_port hostreg_port_chk #(
    .NREG   (NREG),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_n     (rd_n),
    .dout_oe  (dout_oe),
    .dout     (dout),
    .cfg_bus  (cfg_bus),
    .ptr      (ptr),
    .wr_evt   (wr_rise),
    .addr_sel (hold_a)
);

// File: tb/hostreg_port_tb.sv
// Bench: directed scenarios for the host register port, one task per scenario.
module hostreg_port_tb;
    localparam int NREG = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              rd_n = 1'b1, wr_n = 1'b1, aen_n = 1'b1;
    logic [7:0]        din = '0;
    logic [7:0]        dout;
    logic              dout_oe;
    logic [NREG*8-1:0] cfg_bus;
    logic [NREG*8-1:0] model;
    int                n_cmp = 0, n_bad = 0;
    bit                done = 1'b0;

    always #4 clk = ~clk;

    hostreg_port #(.NREG(NREG)) u_dut (
        .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .wr_n(wr_n), .aen_n(aen_n),
        .din(din), .dout(dout), .dout_oe(dout_oe), .cfg_bus(cfg_bus)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        model = '0;
        model[7:0] = 8'h01;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One bus write; addr=1 makes it a pointer load.
    task automatic bus_write(input bit addr, input logic [7:0] d);
        @(negedge clk);
        aen_n = ~addr; din = d; wr_n = 1'b0;
        cycles(4);
        wr_n = 1'b1;
        cycles(1);
        aen_n = 1'b1;
        cycles(3);
    endtask

    task automatic bus_read(input string tag, input logic [7:0] exp);
        @(negedge clk);
        rd_n = 1'b0;
        cycles(4);
        chk({tag, " oe"}, 64'(dout_oe), 64'd1);
        chk({tag, " data"}, 64'(dout), 64'(exp));
        rd_n = 1'b1;
        cycles(4);
        chk({tag, " oe off"}, 64'(dout_oe), 64'd0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        cycles(3);
        model_reset();
        chk("R1 defaults", 64'(cfg_bus), 64'(model));
        chk("R1 oe", 64'(dout_oe), 64'd0);
        rst_n = 1'b1;
        cycles(2);
    endtask

    task automatic t_ignore_in_reset();
        rst_n = 1'b0;
        bus_write(1'b1, 8'h00);
        bus_write(1'b0, 8'h77);
        rst_n = 1'b1;
        cycles(3);
        model_reset();
        chk("R8 ignored in reset", 64'(cfg_bus), 64'(model));
    endtask

    task automatic t_pointer_load();
        bus_write(1'b1, 8'h02);
        chk("R2 no reg change", 64'(cfg_bus), 64'(model));
    endtask

    task automatic t_data_write();
        bus_write(1'b0, 8'hA5);
        model[2*8 +: 8] = 8'hA5;
        chk("R3 R10 write reg2", 64'(cfg_bus), 64'(model));
        bus_read("R4 read reg2", 8'hA5);
    endtask

    task automatic t_no_increment();
        bus_write(1'b0, 8'h3C);
        model[2*8 +: 8] = 8'h3C;
        chk("R7 same reg", 64'(cfg_bus), 64'(model));
        bus_read("R7 read back", 8'h3C);
    endtask

    task automatic t_pending_write();
        bus_write(1'b1, 8'h00);
        @(negedge clk);
        aen_n = 1'b1; din = 8'hFF; wr_n = 1'b0;
        cycles(6);
        chk("R9 held low", 64'(cfg_bus), 64'(model));
        wr_n = 1'b1;
        cycles(4);
        model[7:0] = 8'hFF;
        chk("R9 after rise", 64'(cfg_bus), 64'(model));
    endtask

    task automatic t_top_register();
        bus_write(1'b1, 8'h05);
        bus_write(1'b0, 8'h81);
        model[5*8 +: 8] = 8'h81;
        chk("R10 reg5", 64'(cfg_bus), 64'(model));
        bus_read("R4 read reg5", 8'h81);
    endtask

    task automatic t_unimplemented();
        bus_write(1'b1, 8'h20);
        bus_read("R5 unimpl read", 8'h00);
        bus_write(1'b0, 8'h5A);
        chk("R6 unimpl write", 64'(cfg_bus), 64'(model));
        bus_read("R5 still zero", 8'h00);
    endtask

    initial begin
        model_reset();
        t_reset();
        t_ignore_in_reset();
        t_pointer_load();
        t_data_write();
        t_no_increment();
        t_pending_write();
        t_top_register();
        t_unimplemented();
        t_reset();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule